// File: doc/BRIEF.md
# Sticky Wakeup Reason Recorder

This block keeps a record of why a device came back out of a low-power state. It watches a set of already-enabled peripheral wake lines and two race indications from the power sequencer. The first race indication is a fall-through: an interrupt broke the core out of its wait after the low-power hint had been given, so entry was halted. The second is an abort: a flash, lifecycle or OTP transaction was still running when entry was attempted, so entry was halted. Every reason that is seen while recording is on sets its own sticky bit. Several bits can be set together, and they stay set until software clears them.

Recording is off after reset. It turns on when the sequencer signals the start of a valid low-power entry, and it stays on until the suppress input is raised. The suppress input also blocks recording for as long as it is high. It leaves the bits already recorded untouched. Software clears reasons with a write-one-to-clear strobe. A wake interrupt output is high whenever any recorded bit is set.

Top module: `wake_reason_capture`

## Requirements
- R1: After reset, `reasons_o` is all zeros, `armed_o` is 0 and `wake_irq_o` is 0.
- R2: Bit positions in `reasons_o` are fixed. Bit i, for i below NUM_WAKE, records wake line i. Bit NUM_WAKE records fall-through. Bit NUM_WAKE+1 records abort.
- R3: A recorded bit stays set on every later cycle until a clear addresses it. New reasons are ORed in, so several reasons accumulate.
- R4: Recording is not armed out of reset. A cycle with `entry_start_i`=1 and `cap_dis_i`=0 sets `armed_o` from the next cycle on. Only events sampled while `armed_o`=1 are recorded, so events in the entry cycle itself, or before it, leave `reasons_o` unchanged.
- R5: While `cap_dis_i`=1, no bit of `reasons_o` becomes set, `armed_o` drops to 0 on the next cycle, and reasons already recorded are kept.
- R6: A cycle with `clr_we_i`=1 clears, from the next cycle, exactly those bits of `reasons_o` whose bit in `clr_mask_i` is 1. With `clr_we_i`=0 the mask has no effect.
- R7: If a clear and a recorded event hit the same bit in the same cycle, the event wins and the bit is 1 on the next cycle.
- R8: `wake_irq_o` is 1 exactly when at least one bit of `reasons_o` is 1.
- R9: After suppression has disarmed recording, lowering `cap_dis_i` does not re-arm it. Events stay unrecorded until another entry start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wake_req_i | input | NUM_WAKE | Enabled peripheral wake requests |
| fall_thru_i | input | 1 | Pulse: entry halted by a late interrupt |
| abort_i | input | 1 | Pulse: entry halted by a busy transaction |
| entry_start_i | input | 1 | Pulse: a valid low-power entry begins |
| cap_dis_i | input | 1 | Recording suppress control |
| clr_we_i | input | 1 | Write strobe for the write-one-to-clear |
| clr_mask_i | input | NUM_WAKE+2 | Bits to clear when the strobe is high |
| reasons_o | output | NUM_WAKE+2 | Recorded reasons |
| armed_o | output | 1 | Recording is armed |
| wake_irq_o | output | 1 | OR of all recorded reasons |

## Verification
The bench builds the block with NUM_WAKE set to 4, which gives a 6-bit reason vector. At that width, random wake, race, entry, suppress and clear traffic reaches every bit position many times. Collisions between a clear and a capture on the same bit then happen often, as do arm/disarm sequences that the default width would meet only rarely. Directed steps cover the entry-cycle boundary, re-enabling without a new entry, and clearing everything to drop the interrupt.

// File: rtl/wrc_pkg.sv
`timescale 1ns/1ps
package wrc_pkg;
  localparam int unsigned DEF_NUM_WAKE = 16;
  localparam int unsigned RACE_BITS    = 2;

  // Next state of one sticky bit: a capture beats a clear.
  function automatic logic wrc_next_bit(input logic cur, input logic clr, input logic hit);
    return hit | (cur & ~clr);
  endfunction

  // Arm state update: suppress disarms, entry arms, otherwise hold.
  function automatic logic wrc_next_arm(input logic cur, input logic entry, input logic dis);
    return dis ? 1'b0 : (cur | entry);
  endfunction
endpackage

// File: rtl/wrc_arm_ctrl.sv
`timescale 1ns/1ps
module wrc_arm_ctrl
  import wrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_start_i,
  input  logic cap_dis_i,
  output logic armed_o,
  output logic cap_en_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= wrc_next_arm(armed_q, entry_start_i, cap_dis_i);
  end

  assign armed_o  = armed_q;
  assign cap_en_o = armed_q & ~cap_dis_i;

  AST_ARM_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_start_i && !cap_dis_i) |=> armed_o); // R4
  AST_DISARM_ON_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_dis_i |=> !armed_o); // R5
  AST_NO_SELF_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !entry_start_i) |=> !armed_o); // R9
endmodule

// File: rtl/wrc_reason_bit.sv
`timescale 1ns/1ps
module wrc_reason_bit
  import wrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= wrc_next_bit(q, clr_i, hit_i);
  end

  assign q_o = q;

  AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> q_o); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !q_o); // R6
endmodule

// File: rtl/wake_reason_capture.sv
`timescale 1ns/1ps
module wake_reason_capture
  import wrc_pkg::*;
#(
  parameter int unsigned NUM_WAKE = DEF_NUM_WAKE
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WAKE-1:0]            wake_req_i,
  input  logic                           fall_thru_i,
  input  logic                           abort_i,
  input  logic                           entry_start_i,
  input  logic                           cap_dis_i,
  input  logic                           clr_we_i,
  input  logic [NUM_WAKE+RACE_BITS-1:0]  clr_mask_i,
  output logic [NUM_WAKE+RACE_BITS-1:0]  reasons_o,
  output logic                           armed_o,
  output logic                           wake_irq_o
);
  localparam int unsigned REASON_W = NUM_WAKE + RACE_BITS;
  localparam int unsigned FT_POS   = NUM_WAKE;
  localparam int unsigned AB_POS   = NUM_WAKE + 1;

  // Named internal events for assertions
  logic                cap_en;
  logic [REASON_W-1:0] events;
  logic [REASON_W-1:0] hit;
  logic [REASON_W-1:0] clr;

  wrc_arm_ctrl u_arm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .entry_start_i (entry_start_i),
    .cap_dis_i     (cap_dis_i),
    .armed_o       (armed_o),
    .cap_en_o      (cap_en)
  );

  always_comb begin
    events             = '0;
    events[NUM_WAKE-1:0] = wake_req_i;
    events[FT_POS]     = fall_thru_i;
    events[AB_POS]     = abort_i;
  end

  assign hit = events & {REASON_W{cap_en}};
  assign clr = clr_mask_i & {REASON_W{clr_we_i}};

  for (genvar b = 0; b < REASON_W; b++) begin : g_bit
    wrc_reason_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[b]),
      .clr_i  (clr[b]),
      .q_o    (reasons_o[b])
    );
  end

  assign wake_irq_o = |reasons_o;

  AST_NO_CAPTURE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |=> ((reasons_o & ~$past(reasons_o)) == '0)); // R4
  AST_NO_CAPTURE_SUPPRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_dis_i |=> ((reasons_o & ~$past(reasons_o)) == '0)); // R5
  AST_SUPPRESS_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_dis_i && !clr_we_i) |=> (reasons_o == $past(reasons_o))); // R5
  AST_FT_POSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !cap_dis_i && fall_thru_i) |=> reasons_o[FT_POS]); // R2
  AST_AB_POSITION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !cap_dis_i && abort_i) |=> reasons_o[AB_POS]); // R2
endmodule

// File: tb/wake_reason_capture_tb.sv
`timescale 1ns/1ps
module wake_reason_capture_tb_top;
  localparam int NW = 4;
  localparam int W  = NW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] wake = '0;
  logic          ft = 1'b0, ab = 1'b0, ent = 1'b0, dis = 1'b0, we = 1'b0;
  logic [W-1:0]  mask = '0;
  logic [W-1:0]  reasons;
  logic          armed, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_r = '0;
  logic         m_arm = 1'b0;
  int unsigned  seed = 32'd4711;

  always #2.5 clk = ~clk;

  wake_reason_capture #(.NUM_WAKE(NW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wake_req_i(wake), .fall_thru_i(ft),
    .abort_i(ab), .entry_start_i(ent), .cap_dis_i(dis), .clr_we_i(we),
    .clr_mask_i(mask), .reasons_o(reasons), .armed_o(armed), .wake_irq_o(irq)
  );

  function automatic logic [W-1:0] model_step(input logic [W-1:0] r, input logic arm,
      input logic [NW-1:0] wk, input logic f, input logic a, input logic d,
      input logic w, input logic [W-1:0] m);
    logic [W-1:0] nr = r;
    for (int b = 0; b < W; b++) begin
      logic ev;
      ev = (b < NW) ? wk[b] : ((b == NW) ? f : a);
      if (arm && !d && ev) nr[b] = 1'b1;
      else if (w && m[b])  nr[b] = 1'b0;
    end
    return nr;
  endfunction

  task automatic check(input string tag);
    logic exp_irq;
    exp_irq = (m_r != '0);
    n_chk++;
    if (reasons !== m_r || armed !== m_arm || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: reasons=%b armed=%b irq=%b expected reasons=%b armed=%b irq=%b",
               tag, reasons, armed, irq, m_r, m_arm, exp_irq);
    end
  endtask

  task automatic cyc(input logic [NW-1:0] wk, input logic f, input logic a,
      input logic e, input logic d, input logic w, input logic [W-1:0] m, input string tag);
    wake = wk; ft = f; ab = a; ent = e; dis = d; we = w; mask = m;
    @(posedge clk);
    m_r   = model_step(m_r, m_arm, wk, f, a, d, w, m);
    m_arm = d ? 1'b0 : (m_arm | e);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");
    cyc('1, 1, 1, 0, 0, 0, '0, "R4 events before entry ignored");
    cyc('1, 1, 1, 1, 0, 0, '0, "R4 entry-cycle events ignored, arms");
    cyc(4'b0010, 0, 0, 0, 0, 0, '0, "R2 wake bit 1, R8 irq");
    cyc('0, 1, 0, 0, 0, 0, '0, "R2 fall-through bit");
    cyc('0, 0, 1, 0, 0, 0, '0, "R2 abort bit");
    cyc(4'b1000, 0, 0, 0, 0, 0, '0, "R3 accumulate");
    cyc('0, 0, 0, 0, 0, 0, '0, "R3 sticky hold");
    cyc('0, 0, 0, 0, 0, 0, 6'b010000, "R6 mask without strobe");
    cyc('0, 0, 0, 0, 0, 1, 6'b010000, "R6 clear fall-through");
    cyc(4'b0010, 0, 0, 0, 0, 1, 6'b000010, "R7 capture beats clear");
    cyc(4'b0101, 1, 0, 0, 1, 0, '0, "R5 suppress blocks and disarms");
    cyc(4'b0101, 1, 0, 0, 0, 0, '0, "R9 no rearm without entry");
    cyc('0, 0, 0, 0, 0, 1, '1, "R8 clear all drops irq");
    cyc('0, 0, 0, 1, 0, 0, '0, "R9 entry rearms");
    cyc(4'b0100, 0, 0, 0, 0, 0, '0, "R9 capture after rearm");
    void'($urandom(seed));
    for (int i = 0; i < 3000; i++) begin
      logic [NW-1:0] wk;
      logic f, a, e, d, w;
      logic [W-1:0] m;
      wk = NW'($urandom) & NW'($urandom);
      f  = ($urandom % 6) == 0;
      a  = ($urandom % 6) == 0;
      e  = ($urandom % 10) == 0;
      d  = ($urandom % 8) == 0;
      w  = ($urandom % 4) == 0;
      m  = W'($urandom);
      cyc(wk, f, a, e, d, w, m, "R3 random traffic");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule